// File: doc/BRIEF.md
# DMA Channel Request and Transfer Sequencer

This block runs one DMA channel. A 16-bit mode register picks how the channel works. A start pulse loads a transfer count and a source and destination address. The channel then moves data one transfer at a time, and each transfer waits for a request. The request comes either from an external request pin or from an internal source that is always ready.

Each transfer takes one of two forms:
- **Dual-address transfer:** a source read, with the data captured in a holding register, followed by a destination write.
- **Single-address transfer:** one bus cycle between memory and a peripheral.

One mode bit moves the external acknowledge to the read or the write phase. In single-address mode the same bit sets the direction instead. The external request and done inputs pass through a two-stage synchronizer unless a mode bit bypasses it.

The bus is a plain handshake. The channel drives a cycle request, a write flag, an address and write data, and holds them until the bus returns ready. The operation ends when the count runs out or when the done input is seen. The channel then goes idle and raises a sticky completion flag.

Top module: `dma_chan_seq`

## Requirements
- R1: The mode register is 16 bits and resets to zero. Bit 0 is the control-on-read option, bit 1 is the synchronizer bypass, bit 2 selects single-address mode and bit 3 selects the internal request. Bits 15:4 have no effect. After reset the channel is idle, with busReq, extAck and doneFlag low. A start with the reset mode value runs dual-address transfers with external requests through the synchronizer.
- R2: With bit 1 clear, extReq and extDone pass through two flip-flops. If extReq is first sampled high at clock edge k, with the channel waiting, busReq rises after edge k+2.
- R3: With bit 1 set, extReq and extDone are used directly. If extReq is sampled high at edge k, with the channel waiting, busReq rises after edge k.
- R4: With bit 3 set, extReq is ignored. Each transfer starts on the clock after the channel enters its waiting state.
- R5: In dual-address mode (bit 2 clear), each transfer has two bus cycles:
  - a read (busWrite=0) at the source address;
  - then a write (busWrite=1) at the destination address, whose busWData equals the busRData sampled when the read completed.
- R6: In single-address mode (bit 2 set), each transfer is exactly one bus cycle. With bit 0 clear it is a write at the destination address. With bit 0 set it is a read at the source address.
- R7: extAck is high only during the bus cycle of the control phase, and drops after the edge where busRdy is sampled high. The control phase is:
  - the write cycle in dual-address mode with bit 0 clear;
  - the read cycle in dual-address mode with bit 0 set;
  - the single cycle in single-address mode.
- R8: A bus cycle keeps busReq, busWrite and busAddr steady until busRdy is sampled high.
- R9: Each transfer advances the addresses it used by one. After startCount transfers the channel goes idle and sets doneFlag. A new operation start clears doneFlag.
- R10: If extDone is seen at any point during an operation, the channel finishes the transfer in progress, or the next one if it is waiting. It then goes idle with doneFlag set.
- R11: A start with startCount zero performs no bus cycle and sets doneFlag on the next clock.
- R12: The mode register is copied into the channel only at a start accepted while idle. A mode write or a start pulse made while busy does not change the operation in progress. A later mode write takes effect at the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeWr | input | 1 | Write strobe for the mode register |
| modeData | input | 16 | Mode register write value |
| start | input | 1 | Begin an operation (accepted only when idle) |
| startCount | input | CNT_W | Number of transfers for the operation |
| startSrc | input | ADDR_W | First source address |
| startDst | input | ADDR_W | First destination address |
| extReq | input | 1 | External transfer request |
| extDone | input | 1 | External operation end request |
| extAck | output | 1 | Acknowledge during the control phase's bus cycle |
| busReq | output | 1 | Bus cycle request |
| busWrite | output | 1 | 1 = write cycle, 0 = read cycle |
| busAddr | output | ADDR_W | Bus cycle address |
| busWData | output | DATA_W | Write data (holding register in dual-address writes) |
| busRData | input | DATA_W | Read data, valid with busRdy |
| busRdy | input | 1 | Ends the current bus cycle |
| busy | output | 1 | Operation in progress |
| doneFlag | output | 1 | Sticky completion flag |

## Verification
The assertions assume the bus answers every cycle request within bounded time. They also assume busRData is valid in the cycle busRdy is high. The bench meets this with a responder that derives read data from the address and inserts pseudo-random wait states. The latency checks also assume extReq stays low for at least two clocks before it rises, so the synchronizer starts from a clean low. Every latency scenario idles with extReq low before raising it. Mode writes and start pulses are driven on the falling edge, so each lands in one well-defined clock.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  localparam int MODE_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_RD,
    ST_WR,
    ST_SGL
  } seqState_t;

  // live mode bits copied at start
  typedef struct packed {
    logic reqInternal;
    logic singleAddr;
    logic syncBypass;
    logic ctlOnRead;
  } modeCfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadStart;
    logic capHold;
    logic xferEnd;
  } dpStrobe_t;
endpackage

// File: rtl/dma_seq_dp.sv
module dma_seq_dp
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeWr,
  input  logic [MODE_W-1:0] modeData,
  input  logic [CNT_W-1:0]  startCount,
  input  logic [ADDR_W-1:0] startSrc,
  input  logic [ADDR_W-1:0] startDst,
  input  logic [DATA_W-1:0] busRData,
  input  dpStrobe_t         strobe,
  output modeCfg_t          actCfg,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [DATA_W-1:0] holdData,
  output logic              cntIsOne,
  output logic              startCntZero
);
  localparam int CFG_W = $bits(modeCfg_t);

  logic [CFG_W-1:0] modeLive;
  logic             unusedModeHi;
  logic [CNT_W-1:0] cnt;
  logic             bumpSrc;
  logic             bumpDst;

  // bits above the live field are reserved and dropped
  assign unusedModeHi = ^modeData[MODE_W-1:CFG_W];

  always_ff @(posedge clk) begin
    if (!rstN) modeLive <= '0;
    else if (modeWr) modeLive <= modeData[CFG_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) actCfg <= '0;
    else if (strobe.loadStart) actCfg <= modeCfg_t'(modeLive);
  end

  always_ff @(posedge clk) begin
    if (!rstN) cnt <= '0;
    else if (strobe.loadStart) cnt <= startCount;
    else if (strobe.xferEnd) cnt <= cnt - 1'b1;
  end

  assign cntIsOne     = (cnt == CNT_W'(1));
  assign startCntZero = (startCount == '0);

  // single-address transfers touch only the memory side address
  assign bumpSrc = !actCfg.singleAddr || actCfg.ctlOnRead;
  assign bumpDst = !actCfg.singleAddr || !actCfg.ctlOnRead;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcAddr <= '0;
      dstAddr <= '0;
    end else if (strobe.loadStart) begin
      srcAddr <= startSrc;
      dstAddr <= startDst;
    end else if (strobe.xferEnd) begin
      if (bumpSrc) srcAddr <= srcAddr + 1'b1;
      if (bumpDst) dstAddr <= dstAddr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) holdData <= '0;
    else if (strobe.capHold) holdData <= busRData;
  end

  // R5
  hold_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capHold |=> holdData == $past(busRData));

  // R12
  mode_isolated_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeWr && !strobe.loadStart) |=> $stable(actCfg));
endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      extReq,
  input  logic      extDone,
  input  logic      busRdy,
  input  modeCfg_t  actCfg,
  input  logic      cntIsOne,
  input  logic      startCntZero,
  output dpStrobe_t strobe,
  output logic      busReq,
  output logic      busWrite,
  output logic      selDst,
  output logic      driveHold,
  output logic      extAck,
  output logic      busy,
  output logic      doneFlag
);
  seqState_t state, stateNxt;
  logic reqS1, reqS2, doneS1, doneS2;
  logic reqSeen, doneSeen, reqOk;
  logic doneLatched, finishNow, xferLast;

  // two-stage synchronizers, always running
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqS1  <= 1'b0;
      reqS2  <= 1'b0;
      doneS1 <= 1'b0;
      doneS2 <= 1'b0;
    end else begin
      reqS1  <= extReq;
      reqS2  <= reqS1;
      doneS1 <= extDone;
      doneS2 <= doneS1;
    end
  end

  assign reqSeen  = actCfg.syncBypass ? extReq : reqS2;
  assign doneSeen = actCfg.syncBypass ? extDone : doneS2;
  assign reqOk    = actCfg.reqInternal || reqSeen;
  assign finishNow = cntIsOne || doneLatched || doneSeen;

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    xferLast = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin
        strobe.loadStart = 1'b1;
        stateNxt = startCntZero ? ST_IDLE : ST_WAIT;
      end
      ST_WAIT: if (reqOk) stateNxt = actCfg.singleAddr ? ST_SGL : ST_RD;
      ST_RD: if (busRdy) begin
        strobe.capHold = 1'b1;
        stateNxt = ST_WR;
      end
      ST_WR, ST_SGL: if (busRdy) begin
        strobe.xferEnd = 1'b1;
        xferLast = finishNow;
        stateNxt = finishNow ? ST_IDLE : ST_WAIT;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else state <= stateNxt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) doneLatched <= 1'b0;
    else if (strobe.loadStart) doneLatched <= 1'b0;
    else if (state != ST_IDLE && doneSeen) doneLatched <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) doneFlag <= 1'b0;
    else if (strobe.loadStart) doneFlag <= startCntZero;
    else if (xferLast) doneFlag <= 1'b1;
  end

  assign busy      = (state != ST_IDLE);
  assign busReq    = (state == ST_RD) || (state == ST_WR) || (state == ST_SGL);
  assign selDst    = (state == ST_WR) || (state == ST_SGL && !actCfg.ctlOnRead);
  assign busWrite  = selDst;
  assign driveHold = (state == ST_WR);
  assign extAck    = (state == ST_SGL)
                  || (state == ST_RD && actCfg.ctlOnRead)
                  || (state == ST_WR && !actCfg.ctlOnRead);

  // R7
  ack_in_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    extAck |-> busReq);

  // R5
  read_then_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RD && busRdy) |=> (state == ST_WR));

  // R4
  internal_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && actCfg.reqInternal) |=> (state != ST_WAIT));

  // R8
  cycle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busRdy) |=> (busReq && $stable(busWrite) && $stable(selDst)));

  // R6
  single_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SGL && busRdy) |=> !busReq);

  // R9
  finish_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_WR || state == ST_SGL) && busRdy && cntIsOne) |=> (!busy && doneFlag));
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeWr,
  input  logic [15:0]       modeData,
  input  logic              start,
  input  logic [CNT_W-1:0]  startCount,
  input  logic [ADDR_W-1:0] startSrc,
  input  logic [ADDR_W-1:0] startDst,
  input  logic              extReq,
  input  logic              extDone,
  output logic              extAck,
  output logic              busReq,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWData,
  input  logic [DATA_W-1:0] busRData,
  input  logic              busRdy,
  output logic              busy,
  output logic              doneFlag
);
  dpStrobe_t         strobe;
  modeCfg_t          actCfg;
  logic [ADDR_W-1:0] srcAddr, dstAddr;
  logic [DATA_W-1:0] holdData;
  logic              cntIsOne, startCntZero, selDst, driveHold;

  dma_seq_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .modeWr(modeWr), .modeData(modeData),
    .startCount(startCount), .startSrc(startSrc), .startDst(startDst),
    .busRData(busRData), .strobe(strobe), .actCfg(actCfg),
    .srcAddr(srcAddr), .dstAddr(dstAddr), .holdData(holdData),
    .cntIsOne(cntIsOne), .startCntZero(startCntZero)
  );

  dma_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .extReq(extReq), .extDone(extDone),
    .busRdy(busRdy), .actCfg(actCfg), .cntIsOne(cntIsOne),
    .startCntZero(startCntZero), .strobe(strobe), .busReq(busReq),
    .busWrite(busWrite), .selDst(selDst), .driveHold(driveHold),
    .extAck(extAck), .busy(busy), .doneFlag(doneFlag)
  );

  assign busAddr  = selDst ? dstAddr : srcAddr;
  assign busWData = driveHold ? holdData : '0;
endmodule

// File: tb/dma_chan_seq_tb.sv
module dma_chan_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] M_ECO = 16'h1, M_BYP = 16'h2, M_SGL = 16'h4, M_INT = 16'h8;

  logic clk = 0, rstN = 0;
  logic modeWr = 0, start = 0, extReq = 0, extDone = 0, busRdy = 1;
  logic [15:0] modeData = 0, startCount = 0, startSrc = 0, startDst = 0;
  logic extAck, busReq, busWrite, busy, doneFlag;
  logic [15:0] busAddr, busWData, busRData;

  int checks = 0, fails = 0, cyc = 0, xferSeen = 0;
  logic rdyRand = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign busRData = busAddr ^ 16'h5A3C;

  dma_chan_seq u_dut (
    .clk(clk), .rstN(rstN), .modeWr(modeWr), .modeData(modeData), .start(start),
    .startCount(startCount), .startSrc(startSrc), .startDst(startDst),
    .extReq(extReq), .extDone(extDone), .extAck(extAck), .busReq(busReq),
    .busWrite(busWrite), .busAddr(busAddr), .busWData(busWData),
    .busRData(busRData), .busRdy(busRdy), .busy(busy), .doneFlag(doneFlag)
  );

  // reference model state
  logic [15:0] mMode, mCnt, mSrc, mDst, mHold;
  logic [3:0]  mAct;
  int          mSt; // 0 idle 1 wait 2 read 3 write 4 single
  logic mS1, mS2, mD1, mD2, mDoneSeen, mFlag;

  always @(posedge clk) begin
    logic reqNow, doneNow, fin;
    int oldSt;
    if (!rstN) begin
      mMode = 0; mAct = 0; mSt = 0; mCnt = 0; mSrc = 0; mDst = 0; mHold = 0;
      mS1 = 0; mS2 = 0; mD1 = 0; mD2 = 0; mDoneSeen = 0; mFlag = 0;
    end else begin
      reqNow  = mAct[1] ? extReq : mS2;
      doneNow = mAct[1] ? extDone : mD2;
      mS2 = mS1; mS1 = extReq; mD2 = mD1; mD1 = extDone;
      fin = (mCnt == 1) || mDoneSeen || doneNow;
      oldSt = mSt;
      case (mSt)
        0: if (start) begin
          mAct = mMode[3:0];
          mDoneSeen = 0;
          if (startCount == 0) mFlag = 1;
          else begin
            mSt = 1; mFlag = 0; mCnt = startCount; mSrc = startSrc; mDst = startDst;
          end
        end
        1: if (mAct[3] || reqNow) mSt = mAct[2] ? 4 : 2;
        2: if (busRdy) begin mHold = mSrc ^ 16'h5A3C; mSt = 3; end
        default: if (busRdy) begin
          mCnt = mCnt - 1;
          if (mSt == 3) begin mSrc++; mDst++; end
          else if (mAct[0]) mSrc++;
          else mDst++;
          if (fin) begin mSt = 0; mFlag = 1; end else mSt = 1;
        end
      endcase
      if (oldSt != 0 && doneNow) mDoneSeen = 1;
      if (modeWr) mMode = modeData;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) if (rstN) begin
    logic eReq, eWr, eAck;
    eReq = (mSt >= 2);
    eWr  = (mSt == 3) || (mSt == 4 && !mAct[0]);
    eAck = (mSt == 4) || (mSt == 2 && mAct[0]) || (mSt == 3 && !mAct[0]);
    chk(busReq == eReq, "R8 busReq", 16'(busReq), 16'(eReq));
    chk(busy == (mSt != 0), "R9 busy", 16'(busy), 16'(mSt != 0));
    chk(doneFlag == mFlag, "R9 doneFlag", 16'(doneFlag), 16'(mFlag));
    chk(extAck == eAck, "R7 extAck", 16'(extAck), 16'(eAck));
    if (eReq) begin
      chk(busWrite == eWr, "R6 busWrite", 16'(busWrite), 16'(eWr));
      chk(busAddr == (eWr ? mDst : mSrc), "R5 busAddr", busAddr, eWr ? mDst : mSrc);
    end
    if (mSt == 3) chk(busWData == mHold, "R5 busWData", busWData, mHold);
    if (busReq && busRdy && busWrite) xferSeen++;
  end

  // bus responder: wait states from an LFSR
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    busRdy = rdyRand ? (lfsr[0] | lfsr[1]) : 1'b1;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic startOp(input logic [15:0] mode, input logic [15:0] cnt,
                         input logic [15:0] src, input logic [15:0] dst);
    @(negedge clk); modeWr = 1; modeData = mode;
    @(negedge clk); modeWr = 0; start = 1; startCount = cnt; startSrc = src; startDst = dst;
    @(negedge clk); start = 0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
  endtask

  task automatic latency(input logic byp, input int exp, input string tag);
    int n = 0;
    extReq = 0;
    startOp(byp ? M_BYP : 16'h0, 1, 16'h0300, 16'h0400);
    repeat (4) @(negedge clk);
    chk(!busReq, tag, 16'(busReq), 16'h0);
    extReq = 1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); n++;
      if (busReq) break;
    end
    chk(n == exp, tag, 16'(n), 16'(exp));
    waitIdle();
    extReq = 0;
  endtask

  initial begin
    int firstWr;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !busReq && !extAck && !doneFlag, "R1 reset outputs",
        {12'h0, busy, busReq, extAck, doneFlag}, 16'h0);
    rstN = 1;
    // R1 default mode: dual, external request, first cycle is a read
    extReq = 1;
    @(negedge clk); start = 1; startCount = 3; startSrc = 16'h0100; startDst = 16'h0200;
    @(negedge clk); start = 0;
    for (int i = 0; i < 10 && !busReq; i++) @(negedge clk);
    chk(busReq && !busWrite, "R1 default dual read first", 16'(busWrite), 16'h0);
    waitIdle();
    chk(doneFlag, "R9 done after count", 16'(doneFlag), 16'h1);
    extReq = 0;
    repeat (3) @(negedge clk);

    latency(0, 3, "R2 async latency");
    latency(1, 1, "R3 bypass latency");

    // R4 internal request, DREQ low, wait states
    rdyRand = 1;
    startOp(M_INT, 4, 16'h1000, 16'h2000);
    waitIdle();
    chk(!busy && doneFlag, "R4 internal completes", 16'(doneFlag), 16'h1);

    // R6 single address both directions, R7 control on read in dual
    startOp(M_INT | M_SGL, 3, 16'h1100, 16'h2100); waitIdle();
    startOp(M_INT | M_SGL | M_ECO, 3, 16'h1200, 16'h2200); waitIdle();
    chk(doneFlag, "R6 single ops complete", 16'(doneFlag), 16'h1);
    extReq = 1;
    startOp(M_ECO | M_BYP, 3, 16'h1300, 16'h2300); waitIdle();
    extReq = 0;

    // R10 done input ends early
    xferSeen = 0;
    startOp(M_INT, 10, 16'h1400, 16'h2400);
    repeat (6) @(negedge clk);
    extDone = 1; @(negedge clk); extDone = 0;
    waitIdle();
    chk(xferSeen < 10 && doneFlag, "R10 early end", 16'(xferSeen), 16'd9);

    // R11 zero count
    startOp(M_INT, 0, 16'h1500, 16'h2500);
    chk(!busy && doneFlag && !busReq, "R11 zero count", {14'h0, busy, doneFlag}, 16'h1);

    // R12 mode write and start while busy do not disturb the operation
    rdyRand = 0;
    startOp(M_INT, 4, 16'h1600, 16'h2600);
    @(negedge clk); modeWr = 1; modeData = M_INT | M_SGL; start = 1; startCount = 1;
    @(negedge clk); modeWr = 0; start = 0;
    waitIdle();
    chk(doneFlag, "R12 busy op finished", 16'(doneFlag), 16'h1);
    @(negedge clk); start = 1; startCount = 1; startSrc = 16'h1700; startDst = 16'h2700;
    @(negedge clk); start = 0;
    firstWr = 0;
    for (int i = 0; i < 10; i++) begin
      if (busReq) begin firstWr = busWrite ? 1 : 2; break; end
      @(negedge clk);
    end
    chk(firstWr == 1, "R12 new mode at next start", 16'(firstWr), 16'h1);
    waitIdle();
    repeat (3) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule